// File: doc/BRIEF.md
# Dual Reloading Countdown Timer

This peripheral holds two identical down-counting timers behind a 32-bit register port. Each timer has a control word, a reload value and a current count. Software sets the reload value, then writes a control word with all three enable bits set. That write copies the reload value into the count. From then on, every cycle in which the tick strobe is high lowers the count by one.

When a decrement would take the count below zero, the timer reloads instead and latches a pending interrupt for that timer. Each pending flag drives its own interrupt line toward an interrupt controller. Software acknowledges a timer by writing a one to its bit in the shared status word. A spare 32-bit word is kept for a watchdog control value; it is plain storage with no function behind it.

The port is one access per cycle. A write is taken on the rising clock edge while `we_i` is high. `rdata_o` is a combinational view of the word selected by `addr_i`.

Word addresses with the defaults:

| Address | Word |
|---|---|
| 0 | control, timer 0 |
| 1 | reload value, timer 0 |
| 2 | current count, timer 0 |
| 4 | control, timer 1 |
| 5 | reload value, timer 1 |
| 6 | current count, timer 1 |
| 8 | pending status, bit t for timer t |
| 9 | watchdog storage |

In general, timer t sits at words 4t, 4t+1 and 4t+2. The status word is at 4·N and the watchdog word at 4·N+1, where N is the number of timers.

Top module: `twin_down_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupt outputs are low.
- R2: A timer counts only while bits 31, 30 and 29 of its control word are all 1. With any of them 0, ticks leave the count unchanged.
- R3: A control write whose data has bits 31, 30 and 29 all set loads the count from the reload value. The loaded value is readable in the next cycle.
- R4: While a timer is running, each cycle with `tick_i` high lowers the count by one. A cycle with `tick_i` low leaves the count unchanged.
- R5: A tick on a running timer whose count is 0 or negative reloads the count from the reload value and sets that timer's pending bit. A reload value of V therefore gives an underflow every V+1 ticks.
- R6: A write to a reload value is stored only while that timer is stopped. While the timer runs, the write leaves the old value in place.
- R7: The current count can be read and written directly. A count write in the same cycle as a tick stores the written value.
- R8: Status bit t is timer t's pending flag and drives `irq_o[t]`. Writing 1 to the bit clears it, and writing 0 leaves it unchanged. An underflow in the same cycle as a clear leaves the bit set.
- R9: Clearing any of the three enable bits stops the timer at once, and the count keeps its value.
- R10: The watchdog word stores and returns all 32 bits written to it.
- R11: The timers are independent. Activity on one timer changes neither the count nor the pending bit of the other.
- R12: Addresses that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tick_i | input | 1 | count strobe, one decrement per high cycle |
| we_i | input | 1 | write strobe for the addressed word |
| addr_i | input | ADDR_W | word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data of the addressed word |
| irq_o | output | NUM_TIMERS | per-timer pending interrupt |

## Verification
The bench builds the block with its defaults: NUM_TIMERS of 2 and ADDR_W of 4. With these values both timers can be exercised side by side, and the unmapped gap words and the top word 15 are all reachable. Small reload values of 0 to 15 make underflow happen often. This brings several corner cases within reach many times over:
- an underflow arriving in the same cycle as an acknowledge;
- a reload write landing while the timer runs;
- an enable word with one bit missing.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int DATA_W     = 32;
  localparam int REG_STRIDE = 4;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_INIT   = 1;
  localparam int OFS_CNT    = 2;
  localparam int BIT_IEN    = 29;
  localparam int BIT_CEN    = 30;
  localparam int BIT_GATE   = 31;

  typedef logic [DATA_W-1:0] word_t;

  function automatic logic all_enables(word_t c);
    return c[BIT_IEN] & c[BIT_CEN] & c[BIT_GATE];
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import twin_timer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  ctrl_we_i,
  input  logic  init_we_i,
  input  logic  cnt_we_i,
  input  word_t wdata_i,
  output word_t ctrl_o,
  output word_t init_o,
  output word_t cnt_o,
  output logic  uflow_o
);
  word_t ctrl_q, init_q, cnt_q;
  logic  run;
  logic  [DATA_W:0] dec;
  logic  below_zero;

  assign run        = all_enables(ctrl_q);
  // sign-extended decrement avoids wrap at the most negative value
  assign dec        = {cnt_q[DATA_W-1], cnt_q} - {{DATA_W{1'b0}}, 1'b1};
  assign below_zero = dec[DATA_W];
  assign uflow_o    = run & tick_i & ~ctrl_we_i & ~cnt_we_i & below_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      init_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        ctrl_q <= wdata_i;
        if (all_enables(wdata_i)) cnt_q <= init_q;
      end else if (cnt_we_i) begin
        cnt_q <= wdata_i;
      end else if (run && tick_i) begin
        cnt_q <= below_zero ? init_q : dec[DATA_W-1:0];
      end
      if (init_we_i && !run) init_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign init_o = init_q;
  assign cnt_o  = cnt_q;

  assert_stopped_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !ctrl_we_i && !cnt_we_i) |=> $stable(cnt_q));
  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !ctrl_we_i && !cnt_we_i && !uflow_o) |=> (cnt_q == $past(cnt_q) - word_t'(1)));
  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |=> (cnt_q == $past(init_q)));
  assert_init_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_we_i && run) |=> $stable(init_q));
  assert_ctrl_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && all_enables(wdata_i)) |=> (cnt_q == $past(init_q)));
endmodule

// File: rtl/tmr_pending.sv
module tmr_pending #(
  parameter int NUM = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] uflow_i,
  input  logic           clr_we_i,
  input  logic [NUM-1:0] clr_mask_i,
  output logic [NUM-1:0] pend_o
);
  logic [NUM-1:0] pend_q;
  logic [NUM-1:0] clr;

  assign clr = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | uflow_i;  // set beats clear
  end

  assign pend_o = pend_q;

  assert_pend_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uflow_i) |=> ((pend_q & $past(uflow_i)) == $past(uflow_i)));
  assert_pend_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ((clr_mask_i & ~uflow_i) != '0)) |=> ((pend_q & $past(clr_mask_i & ~uflow_i)) == '0));
endmodule

// File: rtl/twin_down_timer.sv
module twin_down_timer
  import twin_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_TIMERS-1:0] irq_o
);
  localparam int STAT_IDX = REG_STRIDE * NUM_TIMERS;
  localparam int WDOG_IDX = STAT_IDX + 1;

  word_t ctrl_w [NUM_TIMERS];
  word_t init_w [NUM_TIMERS];
  word_t cnt_w  [NUM_TIMERS];
  logic  [NUM_TIMERS-1:0] uflow;
  logic  [NUM_TIMERS-1:0] pend;
  logic  stat_we, wdog_we;
  word_t wdog_q;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    logic sel_ctrl, sel_init, sel_cnt;
    assign sel_ctrl = addr_i == ADDR_W'(g*REG_STRIDE + OFS_CTRL);
    assign sel_init = addr_i == ADDR_W'(g*REG_STRIDE + OFS_INIT);
    assign sel_cnt  = addr_i == ADDR_W'(g*REG_STRIDE + OFS_CNT);

    tmr_channel u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .ctrl_we_i (we_i & sel_ctrl),
      .init_we_i (we_i & sel_init),
      .cnt_we_i  (we_i & sel_cnt),
      .wdata_i   (wdata_i),
      .ctrl_o    (ctrl_w[g]),
      .init_o    (init_w[g]),
      .cnt_o     (cnt_w[g]),
      .uflow_o   (uflow[g])
    );
  end

  assign stat_we = we_i & (addr_i == ADDR_W'(STAT_IDX));
  assign wdog_we = we_i & (addr_i == ADDR_W'(WDOG_IDX));

  tmr_pending #(.NUM(NUM_TIMERS)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .uflow_i    (uflow),
    .clr_we_i   (stat_we),
    .clr_mask_i (wdata_i[NUM_TIMERS-1:0]),
    .pend_o     (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wdog_q <= '0;
    else if (wdog_we) wdog_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (addr_i == ADDR_W'(t*REG_STRIDE + OFS_CTRL)) rdata_o = ctrl_w[t];
      if (addr_i == ADDR_W'(t*REG_STRIDE + OFS_INIT)) rdata_o = init_w[t];
      if (addr_i == ADDR_W'(t*REG_STRIDE + OFS_CNT))  rdata_o = cnt_w[t];
    end
    if (addr_i == ADDR_W'(STAT_IDX)) rdata_o = {{(DATA_W-NUM_TIMERS){1'b0}}, pend};
    if (addr_i == ADDR_W'(WDOG_IDX)) rdata_o = wdog_q;
  end

  assign irq_o = pend;

  assert_irq_needs_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> $past(uflow[0]));
endmodule

// File: tb/twin_down_timer_test.sv
module twin_down_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        tick_i = 0;
  logic        we_i = 0;
  logic [3:0]  addr_i = 0;
  logic [31:0] wdata_i = 0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_ctrl [2];
  logic [31:0] m_init [2];
  logic [31:0] m_cnt  [2];
  logic [1:0]  m_pend;
  logic [31:0] m_wd;

  twin_down_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'd0: return m_ctrl[0];
      4'd1: return m_init[0];
      4'd2: return m_cnt[0];
      4'd4: return m_ctrl[1];
      4'd5: return m_init[1];
      4'd6: return m_cnt[1];
      4'd8: return {30'd0, m_pend};
      4'd9: return m_wd;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd0, 4'd4: return "R3";
      4'd1, 4'd5: return "R6";
      4'd2, 4'd6: return "R4";
      4'd8:       return "R8";
      4'd9:       return "R10";
      default:    return "R12";
    endcase
  endfunction

  function automatic logic enabled(logic [31:0] c);
    return c[31] && c[30] && c[29];
  endfunction

  // model of one clock edge, using the state before the edge
  task automatic model_step(logic we, logic [3:0] a, logic [31:0] d, logic tk);
    logic [1:0] uf = 2'b00;
    for (int t = 0; t < 2; t++) begin
      logic run = enabled(m_ctrl[t]);
      if (we && a == 4'(4*t)) begin
        m_ctrl[t] = d;
        if (enabled(d)) m_cnt[t] = m_init[t];
      end else if (we && a == 4'(4*t+2)) begin
        m_cnt[t] = d;
      end else if (run && tk) begin
        if ($signed(m_cnt[t]) <= 0) begin
          m_cnt[t] = m_init[t];
          uf[t] = 1'b1;
        end else begin
          m_cnt[t] = m_cnt[t] - 1;
        end
      end
      if (we && a == 4'(4*t+1) && !run) m_init[t] = d;
    end
    if (we && a == 4'd8) m_pend = m_pend & ~d[1:0];
    m_pend = m_pend | uf;
    if (we && a == 4'd9) m_wd = d;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle; a read (we=0) compares rdata against exp
  task automatic cyc(logic we, logic [3:0] a, logic [31:0] d, logic tk);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    #1;
    model_step(we, a, d, tk);
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    we_i = 0; addr_i = a; wdata_i = 0; tick_i = 0;
    #1;
    check(tag, rdata_o, exp);
    check(tag, rdata_o, exp_read(a));
    model_step(1'b0, a, 32'd0, 1'b0);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd3, 32'd0, 1'b1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int t = 0; t < 2; t++) begin
      m_ctrl[t] = 0; m_init[t] = 0; m_cnt[t] = 0;
    end
    m_pend = 0; m_wd = 0;
    void'($urandom(32'h5eed));
    #(CLK_PERIOD*3) rst_ni = 1;

    // R1 reset state
    for (int a = 0; a < 16; a++) rd(4'(a), 32'd0, "R1");
    check("R1", {30'd0, irq_o}, 32'd0);

    // R2 partial enables do not count
    wr(4'd1, 32'd5);
    wr(4'd0, 32'h6000_0000);
    ticks(3);
    rd(4'd2, 32'd0, "R2");
    wr(4'd0, 32'hA000_0000);
    ticks(2);
    rd(4'd2, 32'd0, "R2");

    // R3 enabling control write loads count
    wr(4'd0, 32'hE000_0000);
    rd(4'd2, 32'd5, "R3");

    // R4 decrement per tick, hold without tick
    ticks(2);
    rd(4'd2, 32'd3, "R4");
    rd(4'd2, 32'd3, "R4");

    // R6 reload write ignored while running
    wr(4'd1, 32'd9);
    rd(4'd1, 32'd5, "R6");

    // R5 underflow below zero
    ticks(3);
    rd(4'd2, 32'd0, "R5");
    check("R5", {30'd0, irq_o}, 32'd0);
    ticks(1);
    rd(4'd2, 32'd5, "R5");
    rd(4'd8, 32'd1, "R5");
    check("R8", {30'd0, irq_o}, 32'd1);

    // R8 write-one-to-clear
    wr(4'd8, 32'd0);
    rd(4'd8, 32'd1, "R8");
    wr(4'd8, 32'd1);
    rd(4'd8, 32'd0, "R8");
    check("R8", {30'd0, irq_o}, 32'd0);

    // R9 stop holds count
    ticks(2);
    wr(4'd0, 32'hC000_0000);
    ticks(3);
    rd(4'd2, 32'd3, "R9");
    wr(4'd1, 32'd7);
    rd(4'd1, 32'd7, "R6");

    // R7 direct count write, beats tick
    wr(4'd2, 32'h12);
    rd(4'd2, 32'h12, "R7");
    wr(4'd0, 32'hE000_0000);
    rd(4'd2, 32'd7, "R3");
    cyc(1'b1, 4'd2, 32'h40, 1'b1);
    rd(4'd2, 32'h40, "R7");

    // R10 watchdog storage
    wr(4'd9, 32'hDEAD_BEEF);
    rd(4'd9, 32'hDEAD_BEEF, "R10");

    // R11 independence
    wr(4'd0, 32'd0);
    wr(4'd5, 32'd1);
    wr(4'd4, 32'hE000_0000);
    rd(4'd6, 32'd1, "R11");
    ticks(2);
    rd(4'd8, 32'd2, "R11");
    check("R11", {30'd0, irq_o}, 32'd2);
    rd(4'd2, 32'h40, "R11");
    wr(4'd8, 32'd2);
    rd(4'd8, 32'd0, "R11");

    // R12 unmapped
    rd(4'd3, 32'd0, "R12");
    rd(4'd15, 32'd0, "R12");

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      logic        we, tk;
      int pick = $urandom_range(0, 10);
      a  = (pick == 10) ? 4'd15 : 4'(pick);
      we = $urandom_range(0, 1) == 1;
      tk = $urandom_range(0, 9) < 7;
      case (a)
        4'd0, 4'd4: begin
          case ($urandom_range(0, 4))
            0: d = 32'hE000_0000;
            1: d = 32'h6000_0000;
            2: d = 32'hC000_0000;
            3: d = 32'hA000_0000 | 32'($urandom_range(0, 255));
            default: d = 32'hE000_0000 | 32'($urandom_range(0, 255));
          endcase
        end
        4'd1, 4'd5, 4'd2, 4'd6: d = 32'($urandom_range(0, 15));
        4'd8: d = 32'($urandom_range(0, 3));
        default: d = $urandom;
      endcase
      @(negedge clk_i);
      we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
      #1;
      check("R8", {30'd0, irq_o}, {30'd0, m_pend});
      if (!we) check(tag_of(a), rdata_o, exp_read(a));
      model_step(we, a, d, tk);
    end

    @(negedge clk_i);
    we_i = 0; tick_i = 0;
    summary();
    $finish;
  end
endmodule